// File: doc/BRIEF.md
# Sub-word multiply-accumulate unit

This block multiplies one lane of a 32-bit word by one lane of a second operand, then adds a full 32-bit addend. It can shift the sum right by a fixed amount before it registers the result. For each multiplicand the caller picks either a single byte, chosen by a 2-bit index, or one 16-bit half of the source word. The second multiplicand can also come from a 16-bit immediate. Each operand carries its own signedness flag. If either flag is set, the post-shift is arithmetic.

The datapath between the inputs and the output register is purely combinational. A strobe qualifies each operation, and the result, a valid flag and an error flag all appear one clock later. The error flag marks an operation whose lane type has no defined selection, either the full-word type or the reserved type. That operand is then taken as zero.

Top module: `svmac_unit`

## Requirements
- R1: With chunk mode off, an operand equals bits [8*idx+7 : 8*idx] of its source word, zero-extended to 32 bits. The 2-bit byte index idx selects the byte, and idx 0 is the least significant byte.
- R2: With chunk mode on and type code 0, an operand equals the low 16 bits of its source word, zero-extended.
- R3: With chunk mode on and type code 1, an operand equals the source word shifted right logically by 16.
- R4: With chunk mode on and type code 2 or 3, the operand is zero and err_o is 1 for that operation. For operand B this holds only when use_b_reg_i is 1. err_o is 0 for any operation with no such operand.
- R5: With use_b_reg_i at 0, operand B is imm_i. It is sign-extended to 32 bits when b_signed_i is 1 and zero-extended otherwise. The chunk, type and index inputs of B then have no effect on result_o or err_o.
- R6: The unshifted value is the low 32 bits of A*B + c_i. Shift code 0 and shift code 3 output this value directly.
- R7: Shift code 1 shifts the value right by 7 and shift code 2 shifts it right by 15. The shift is arithmetic when a_signed_i or b_signed_i is 1, and logical otherwise.
- R8: valid_o equals valid_i delayed by one clock. result_o and err_o for an operation appear in that same cycle.
- R9: In a cycle where valid_i is 0, result_o and err_o keep their values at the next clock.
- R10: While rst_ni is low, valid_o, result_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| a_i | input | 32 | Source word for operand A |
| b_i | input | 32 | Source word for operand B |
| c_i | input | 32 | Addend |
| imm_i | input | 16 | Immediate for operand B |
| a_chunk_i | input | 1 | A: 1 selects a halfword type, 0 selects a byte |
| a_signed_i | input | 1 | A: signed flag |
| a_type_i | input | 2 | A: 0 low half, 1 high half, 2/3 unsupported |
| a_byte_i | input | 2 | A: byte index |
| b_chunk_i | input | 1 | B: 1 selects a halfword type, 0 selects a byte |
| b_signed_i | input | 1 | B: signed flag, also picks immediate extension |
| b_type_i | input | 2 | B: 0 low half, 1 high half, 2/3 unsupported |
| b_byte_i | input | 2 | B: byte index |
| use_b_reg_i | input | 1 | 1: B from b_i, 0: B from imm_i |
| shift_i | input | 2 | 0/3 none, 1 by 7, 2 by 15 |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Result valid |
| err_o | output | 1 | Unsupported lane type used |

## Verification
Directed cases run each lane selection on its own, with distinctive byte patterns, so a wrong index or a swapped half yields a different product. Both immediate extensions are tried with a top-bit-set immediate, where zero extension and sign extension give different products. Both shifts are applied to a sum whose top bit is set, with signed and unsigned flags, so an arithmetic shift and a logical shift are told apart. Randomised operations, a few of them with unsupported types, cover the mix of lane, source and shift choices. They also confirm that the B selectors have no effect while the immediate is in use, and that the outputs hold while the strobe is low.

// File: rtl/svmac_pkg.sv
package svmac_pkg;
  typedef enum logic [1:0] {
    HW_LO   = 2'd0,
    HW_HI   = 2'd1,
    HW_WORD = 2'd2,
    HW_RSVD = 2'd3
  } hw_sel_e;

  typedef enum logic [1:0] {
    SH_NONE  = 2'd0,
    SH_SMALL = 2'd1,
    SH_LARGE = 2'd2,
    SH_ALT   = 2'd3
  } shift_mode_e;
endpackage

// File: rtl/svmac_lane.sv
module svmac_lane
  import svmac_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int IDX_W = $clog2(NLANE),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic              chunk_i,
  input  hw_sel_e           hw_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] op_o,
  output logic              err_o
);
  logic [NLANE-1:0][LANE_W-1:0] lanes;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lanes[g] = word_i[g*LANE_W +: LANE_W];
  end

  always_comb begin
    op_o  = '0;
    err_o = 1'b0;
    if (!chunk_i) begin
      op_o[LANE_W-1:0] = lanes[idx_i];
    end else begin
      unique case (hw_i)
        HW_LO:   op_o[HALF_W-1:0] = word_i[HALF_W-1:0];
        HW_HI:   op_o[HALF_W-1:0] = word_i[DATA_W-1:HALF_W];
        default: err_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    p_byte_width_r1: assert (chunk_i || op_o[DATA_W-1:LANE_W] == '0);
    p_half_width_r2: assert (!chunk_i || op_o[DATA_W-1:HALF_W] == '0);
    p_err_zero_r4:   assert (!err_o || op_o == '0);
  end
endmodule

// File: rtl/svmac_bsrc.sv
module svmac_bsrc #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16,
  localparam int EXT_W = DATA_W - IMM_W
) (
  input  logic              use_reg_i,
  input  logic              sgn_i,
  input  logic [DATA_W-1:0] lane_op_i,
  input  logic              lane_err_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] op_o,
  output logic              err_o
);
  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1] & sgn_i}}, imm_i};

  always_comb begin
    if (use_reg_i) begin
      op_o  = lane_op_i;
      err_o = lane_err_i;
    end else begin
      op_o  = imm_ext;
      err_o = 1'b0;
    end
  end

  always_comb begin
    p_imm_no_err_r5: assert (use_reg_i || !err_o);
    p_imm_zext_r5:   assert (use_reg_i || sgn_i || op_o[DATA_W-1:IMM_W] == '0);
  end
endmodule

// File: rtl/svmac_core.sv
module svmac_core
  import svmac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int SHIFT_S = 7,
  parameter int SHIFT_L = 15
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic              sgn_i,
  input  shift_mode_e       mode_i,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] prod;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] sh_s;
  logic [DATA_W-1:0] sh_l;

  // low word of the product is the same for either signedness
  assign prod = a_i * b_i;
  assign sum  = prod + c_i;
  assign sh_s = sgn_i ? DATA_W'($signed(sum) >>> SHIFT_S) : (sum >> SHIFT_S);
  assign sh_l = sgn_i ? DATA_W'($signed(sum) >>> SHIFT_L) : (sum >> SHIFT_L);

  always_comb begin
    unique case (mode_i)
      SH_SMALL: res_o = sh_s;
      SH_LARGE: res_o = sh_l;
      default:  res_o = sum;
    endcase
  end

  always_comb begin
    p_lsr_small_r7: assert (sgn_i || mode_i != SH_SMALL || res_o[DATA_W-1 -: SHIFT_S] == '0);
    p_lsr_large_r7: assert (sgn_i || mode_i != SH_LARGE || res_o[DATA_W-1 -: SHIFT_L] == '0);
  end
endmodule

// File: rtl/svmac_unit.sv
module svmac_unit
  import svmac_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_W   = 16,
  parameter int LANE_W  = 8,
  parameter int SHIFT_S = 7,
  parameter int SHIFT_L = 15,
  localparam int IDX_W  = $clog2(DATA_W / LANE_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] c_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              a_chunk_i,
  input  logic              a_signed_i,
  input  logic [1:0]        a_type_i,
  input  logic [IDX_W-1:0]  a_byte_i,
  input  logic              b_chunk_i,
  input  logic              b_signed_i,
  input  logic [1:0]        b_type_i,
  input  logic [IDX_W-1:0]  b_byte_i,
  input  logic              use_b_reg_i,
  input  logic [1:0]        shift_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              err_o
);
  logic [1:0][DATA_W-1:0] src_w;
  logic [1:0]             src_chunk;
  hw_sel_e [1:0]          src_hw;
  logic [1:0][IDX_W-1:0]  src_idx;
  logic [1:0][DATA_W-1:0] lane_op;
  logic [1:0]             lane_err;

  assign src_w     = {b_i, a_i};
  assign src_chunk = {b_chunk_i, a_chunk_i};
  assign src_hw    = {hw_sel_e'(b_type_i), hw_sel_e'(a_type_i)};
  assign src_idx   = {b_byte_i, a_byte_i};

  for (genvar g = 0; g < 2; g++) begin : g_src
    svmac_lane #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
      .word_i (src_w[g]),
      .chunk_i(src_chunk[g]),
      .hw_i   (src_hw[g]),
      .idx_i  (src_idx[g]),
      .op_o   (lane_op[g]),
      .err_o  (lane_err[g])
    );
  end

  logic [DATA_W-1:0] op_b;
  logic              err_b;

  svmac_bsrc #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_bsrc (
    .use_reg_i (use_b_reg_i),
    .sgn_i     (b_signed_i),
    .lane_op_i (lane_op[1]),
    .lane_err_i(lane_err[1]),
    .imm_i     (imm_i),
    .op_o      (op_b),
    .err_o     (err_b)
  );

  logic [DATA_W-1:0] res_d;

  svmac_core #(.DATA_W(DATA_W), .SHIFT_S(SHIFT_S), .SHIFT_L(SHIFT_L)) u_core (
    .a_i   (lane_op[0]),
    .b_i   (op_b),
    .c_i   (c_i),
    .sgn_i (a_signed_i | b_signed_i),
    .mode_i(shift_mode_e'(shift_i)),
    .res_o (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      err_o    <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        err_o    <= lane_err[0] | err_b;
      end
    end
  end

  p_valid_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  p_valid_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(err_o)));
  p_err_cause_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !a_chunk_i && (!use_b_reg_i || !b_chunk_i)) |=> !err_o);
endmodule

// File: tb/sim_svmac_unit.sv
module sim_svmac_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [31:0] a = '0, b = '0, c = '0;
  logic [15:0] imm = '0;
  logic        a_ch = 0, a_sg = 0, b_ch = 0, b_sg = 0, use_b = 0;
  logic [1:0]  a_hw = 0, a_ix = 0, b_hw = 0, b_ix = 0, shm = 0;
  logic [31:0] result;
  logic        valid, err;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  svmac_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(vld),
    .a_i(a), .b_i(b), .c_i(c), .imm_i(imm),
    .a_chunk_i(a_ch), .a_signed_i(a_sg), .a_type_i(a_hw), .a_byte_i(a_ix),
    .b_chunk_i(b_ch), .b_signed_i(b_sg), .b_type_i(b_hw), .b_byte_i(b_ix),
    .use_b_reg_i(use_b), .shift_i(shm),
    .result_o(result), .valid_o(valid), .err_o(err)
  );

  function automatic logic [32:0] f_lane(logic [31:0] w, logic ch, logic [1:0] hw, logic [1:0] ix);
    if (!ch) return {1'b0, 24'h0, w[ix*8 +: 8]};
    case (hw)
      2'd0:    return {1'b0, 16'h0, w[15:0]};
      2'd1:    return {1'b0, 16'h0, w[31:16]};
      default: return {1'b1, 32'h0};
    endcase
  endfunction

  function automatic logic [32:0] f_model();
    logic [32:0] la, lb;
    logic [31:0] opb, s;
    logic        e, sg;
    la = f_lane(a, a_ch, a_hw, a_ix);
    lb = f_lane(b, b_ch, b_hw, b_ix);
    if (use_b) begin
      opb = lb[31:0];
      e   = la[32] | lb[32];
    end else begin
      opb = b_sg ? {{16{imm[15]}}, imm} : {16'h0, imm};
      e   = la[32];
    end
    sg = a_sg | b_sg;
    s  = la[31:0] * opb + c;
    case (shm)
      2'd1:    s = sg ? 32'($signed(s) >>> 7)  : s >> 7;
      2'd2:    s = sg ? 32'($signed(s) >>> 15) : s >> 15;
      default: ;
    endcase
    return {e, s};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(string tag);
    logic [32:0] e;
    @(negedge clk);
    vld = 1'b1;
    e = f_model();
    @(posedge clk);
    #1;
    chk({tag, " result"}, result, e[31:0]);
    chk({tag, " err"}, {31'h0, err}, {31'h0, e[32]});
    chk("R8 valid", {31'h0, valid}, 32'h1);
  endtask

  task automatic set_op(logic [31:0] na, nb, nc, logic [15:0] ni,
                        logic ach, asg, logic [1:0] ahw, aix,
                        logic bch, bsg, logic [1:0] bhw, bix, logic ub, logic [1:0] sm);
    a = na; b = nb; c = nc; imm = ni;
    a_ch = ach; a_sg = asg; a_hw = ahw; a_ix = aix;
    b_ch = bch; b_sg = bsg; b_hw = bhw; b_ix = bix;
    use_b = ub; shm = sm;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] held;
    logic        held_e;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset valid", {31'h0, valid}, 32'h0);
    chk("R10 reset result", result, 32'h0);
    chk("R10 reset err", {31'h0, err}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      set_op(32'hA1B2C3D4, 0, 32'h0, 16'h0003, 0, 0, 0, i[1:0], 0, 0, 0, 0, 0, 0);
      go("R1 byte select");
    end
    set_op(32'h0, 32'h9F00_7E00, 32'h10, 16'h0, 0, 0, 0, 0, 0, 0, 0, 2'd1, 1, 0);
    a = 32'h0000_0005;
    go("R1 reg B byte");
    set_op(32'h8765_4321, 0, 32'h0, 16'h0002, 1, 0, 2'd0, 0, 0, 0, 0, 0, 0, 0);
    go("R2 low half");
    set_op(32'h8001_1234, 32'h0003_0000, 32'h7, 16'h0, 1, 0, 2'd1, 0, 1, 0, 2'd1, 0, 1, 0);
    go("R3 high half");
    set_op(32'h1234_5678, 0, 32'hCAFE_0001, 16'h0009, 1, 0, 2'd2, 0, 0, 0, 0, 0, 0, 0);
    go("R4 word type A");
    set_op(32'h0000_0010, 32'hFFFF_FFFF, 32'h55, 16'h0, 0, 0, 0, 0, 1, 0, 2'd3, 0, 1, 0);
    go("R4 reserved type B");
    set_op(32'h0000_0005, 32'hFFFF_FFFF, 32'h0, 16'hFFFF, 0, 0, 0, 0, 1, 1, 2'd3, 0, 0, 0);
    go("R5 imm signed, B selectors ignored");
    set_op(32'h0000_0005, 32'h1234_5678, 32'h0, 16'hFFFF, 0, 0, 0, 0, 1, 0, 2'd2, 0, 0, 0);
    go("R5 imm unsigned");
    set_op(32'h0000_00FF, 0, 32'h8000_0000, 16'h0001, 0, 1, 0, 0, 0, 0, 0, 0, 0, 2'd1);
    go("R7 asr 7");
    set_op(32'h0000_00FF, 0, 32'h8000_0000, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd1);
    go("R7 lsr 7");
    set_op(32'h0000_00FF, 0, 32'h8000_0000, 16'h0001, 0, 0, 0, 0, 0, 1, 0, 0, 0, 2'd2);
    go("R7 asr 15");
    set_op(32'h0000_00FF, 0, 32'h8000_0000, 16'h0001, 0, 0, 0, 0, 0, 0, 0, 0, 0, 2'd2);
    go("R7 lsr 15");
    set_op(32'h0000_FFFF, 32'h0000_FFFF, 32'h9, 16'h0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 2'd3);
    go("R6 shift code 3");

    // hold while strobe low
    held = result; held_e = err;
    @(negedge clk);
    vld = 1'b0;
    a = 32'hFFFF_FFFF; c = 32'h1234; a_ch = 1; a_hw = 2'd2;
    @(posedge clk);
    #1;
    chk("R8 valid low", {31'h0, valid}, 32'h0);
    chk("R9 hold result", result, held);
    chk("R9 hold err", {31'h0, err}, {31'h0, held_e});

    for (int i = 0; i < 400; i++) begin
      set_op($urandom, $urandom, $urandom, 16'($urandom),
             1'($urandom), 1'($urandom), ($urandom % 8 == 0) ? 2'($urandom) : 2'($urandom % 2),
             2'($urandom), 1'($urandom), 1'($urandom),
             ($urandom % 8 == 0) ? 2'($urandom) : 2'($urandom % 2),
             2'($urandom), 1'($urandom), 2'($urandom));
      go("R6 random");
    end

    @(negedge clk);
    vld = 1'b0;
    @(posedge clk);
    #1;
    chk("R8 valid drop", {31'h0, valid}, 32'h0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule